// File: doc/BRIEF.md
# SCSI Host Adapter Control, Status and Interrupt Registers

This block is the host-visible register file of a SCSI host adapter. A 16-bit register port lets software drive the reset lines of the protocol controller and the data FIFO. The same port sets the transfer direction, DMA enable, byte packing and interrupt enable. Software also loads the DMA address, the DMA count, the FIFO byte count and the interrupt vector with its bus address modifier. All of these values leave the block as plain outputs.

The block gathers two interrupt sources: a completion event from the DMA engine and a request from the protocol controller. It keeps a pending bit for each source. It drives one interrupt line, which is gated by the interrupt enable. It also shows live FIFO status, the leftover byte count and two sticky error flags. The DMA datapath and the FIFO storage sit outside this block and are seen only through status inputs.

Register select codes: 0 control/status, 1 vector/modifier, 2 DMA address low 16 bits, 3 DMA address upper bits, 4 DMA count, 5 FIFO byte count, 6 interrupt acknowledge. Reads return data in the cycle after `reg_rd` is sampled, and `reg_rdata` holds its value between reads. Select codes 6 and 7 read as zero.

Top module: `scsi_hba_csr`

## Requirements
- R1: On system reset, every register clears to zero. This means `sbc_rst_n` and `fifo_rst_n` come up low, so both functions are held in reset, and `irq` is low.
- R2: A write to select 0 loads bits 5:0 into the control fields: bit 0 protocol-controller reset (active low), bit 1 FIFO reset (active low), bit 2 interrupt enable, bit 3 direction (1 = toward the device), bit 4 DMA enable, bit 5 longword packing. Writing bits 15:6 has no effect.
- R3: A pending bit is set only while the interrupt enable is 1 and its source input is high: bit 8 for `dma_irq_in`, bit 9 for `sbc_irq_in`. Clearing the enable keeps pending bits but forces `irq` low. `irq` always equals the enable AND (bit 8 OR bit 9).
- R4: A read of select 6 clears the protocol-controller pending bit. If `sbc_irq_in` is high and the interrupt enable is 1 in the same cycle, the bit stays set.
- R5: A write to the DMA count (select 4) clears the DMA pending bit, unless a new DMA event arrives in the same cycle.
- R6: A write to select 4 loads the DMA count and also loads the FIFO byte count with its low FCNT_W bits. A write to select 5 loads the FIFO byte count and also loads the DMA count with the same value, zero-extended.
- R7: Select 1 holds an 8-bit vector in bits 7:0 and a 6-bit address modifier in bits 13:8. Bits 15:14 read as zero.
- R8: A read of select 0 returns the control fields in bits 5:0, `left_bytes` in 7:6, DMA pending in 8, protocol pending in 9, `fifo_empty` in 10 and `fifo_full` in 11. Bits 12 and 15 read as zero. Status inputs are sampled on the read cycle.
- R9: Bit 13 is set by `dma_bus_err`. Bit 14 is set by any register write while `dma_active` is high. Both bits stay set until the FIFO reset field is 0, which clears them and keeps them clear.
- R10: Select 2 writes DMA address bits 15:0 and select 3 writes the upper DADDR_W-16 bits. Both read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| sbc_irq_in | input | 1 | Protocol-controller interrupt request |
| dma_irq_in | input | 1 | DMA completion event |
| fifo_empty | input | 1 | FIFO empty status |
| fifo_full | input | 1 | FIFO full status |
| left_bytes | input | 2 | Leftover byte count from the DMA engine |
| dma_bus_err | input | 1 | Bus error seen during DMA |
| dma_active | input | 1 | DMA transfer in progress |
| irq | output | 1 | Interrupt request to the host |
| sbc_rst_n | output | 1 | Protocol-controller reset, active low |
| fifo_rst_n | output | 1 | FIFO reset, active low |
| dir_to_dev | output | 1 | Transfer direction, 1 toward the device |
| dma_en | output | 1 | DMA enable |
| pack_long | output | 1 | Longword byte packing select |
| dma_addr | output | DADDR_W | DMA address |
| dma_count | output | CNT_W | DMA byte count |
| fifo_count | output | FCNT_W | FIFO byte count |
| int_vector | output | 8 | Interrupt vector |
| addr_mod | output | 6 | Bus address modifier |

## Verification
The bench builds the block with DADDR_W=24, CNT_W=16 and FCNT_W=12. A FIFO count narrower than the DMA count makes the cross-load visible in both directions: a DMA-count write truncates into the FIFO count, and a FIFO-count write is zero-extended into the DMA count. The 24-bit address gives the upper half a width of 8 bits, so the test can show that bits above it are dropped on write and read back as zero. Under these settings the reference model tracks the pending-bit races against the acknowledge read and the count write, and the sticky flag clearing behind the FIFO reset.

// File: rtl/scsi_hba_csr_pkg.sv
package scsi_hba_csr_pkg;
  localparam int RA_W  = 3;
  localparam int REG_W = 16;
  localparam int CTL_W = 6;
  localparam int VEC_W = 8;
  localparam int AM_W  = 6;

  typedef enum logic [RA_W-1:0] {
    SEL_CTL    = 3'd0,
    SEL_VEC    = 3'd1,
    SEL_ADR_LO = 3'd2,
    SEL_ADR_HI = 3'd3,
    SEL_DCNT   = 3'd4,
    SEL_FCNT   = 3'd5,
    SEL_IACK   = 3'd6
  } reg_sel_e;

  // Writable control fields; packed so field 0 is the LSB.
  typedef struct packed {
    logic pack_long;
    logic dma_en;
    logic dir_to_dev;
    logic ie;
    logic fifo_rst_n;
    logic sbc_rst_n;
  } ctl_t;
endpackage

// File: rtl/scsi_hba_ctl.sv
module scsi_hba_ctl
  import scsi_hba_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [RA_W-1:0]  addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             sbc_src,
  input  logic             dma_src,
  input  logic             dma_bus_err,
  input  logic             dma_active,
  output ctl_t             ctl_q,
  output logic             dma_pend_q,
  output logic             sbc_pend_q,
  output logic             berr_q,
  output logic             acc_q,
  output logic             irq_q
);
  ctl_t ctl_d;
  logic dp_d, sp_d, berr_d, acc_d;
  logic wr_ctl, wr_dcnt, rd_ack;

  assign wr_ctl  = wr_en && (addr == SEL_CTL);
  assign wr_dcnt = wr_en && (addr == SEL_DCNT);
  assign rd_ack  = rd_en && (addr == SEL_IACK);

  always_comb begin
    ctl_d = wr_ctl ? ctl_t'(wdata[CTL_W-1:0]) : ctl_q;
    // clear first, then a new event (taken only when enabled) wins
    dp_d = dma_pend_q && !wr_dcnt;
    if (ctl_q.ie && dma_src) dp_d = 1'b1;
    sp_d = sbc_pend_q && !rd_ack;
    if (ctl_q.ie && sbc_src) sp_d = 1'b1;
    // sticky error flags live only while the FIFO is out of reset
    berr_d = ctl_q.fifo_rst_n && (berr_q || dma_bus_err);
    acc_d  = ctl_q.fifo_rst_n && (acc_q || (wr_en && dma_active));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      dma_pend_q <= 1'b0;
      sbc_pend_q <= 1'b0;
      berr_q     <= 1'b0;
      acc_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      ctl_q      <= ctl_d;
      dma_pend_q <= dp_d;
      sbc_pend_q <= sp_d;
      berr_q     <= berr_d;
      acc_q      <= acc_d;
      irq_q      <= ctl_d.ie && (dp_d || sp_d);
    end
  end
endmodule

// File: rtl/scsi_hba_xfer_regs.sv
module scsi_hba_xfer_regs
  import scsi_hba_csr_pkg::*;
#(
  parameter int DADDR_W = 24,
  parameter int CNT_W   = 16,
  parameter int FCNT_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [RA_W-1:0]    addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [DADDR_W-1:0] dma_addr_q,
  output logic [CNT_W-1:0]   dma_cnt_q,
  output logic [FCNT_W-1:0]  fifo_cnt_q,
  output logic [VEC_W-1:0]   vec_q,
  output logic [AM_W-1:0]    am_q
);
  localparam int LO_W = (DADDR_W > REG_W) ? REG_W : DADDR_W;
  localparam int HI_W = DADDR_W - LO_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_cnt_q  <= '0;
      fifo_cnt_q <= '0;
      vec_q      <= '0;
      am_q       <= '0;
    end else if (wr_en) begin
      case (addr)
        SEL_DCNT: begin
          dma_cnt_q  <= wdata[CNT_W-1:0];
          fifo_cnt_q <= wdata[FCNT_W-1:0];
        end
        SEL_FCNT: begin
          fifo_cnt_q <= wdata[FCNT_W-1:0];
          dma_cnt_q  <= CNT_W'(wdata[FCNT_W-1:0]);
        end
        SEL_VEC: begin
          vec_q <= wdata[VEC_W-1:0];
          am_q  <= wdata[VEC_W+AM_W-1:VEC_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dma_addr_q[LO_W-1:0] <= '0;
    else if (wr_en && addr == SEL_ADR_LO) dma_addr_q[LO_W-1:0] <= wdata[LO_W-1:0];
  end

  generate
    if (HI_W > 0) begin : g_addr_hi
      always_ff @(posedge clk) begin
        if (rst) dma_addr_q[DADDR_W-1:LO_W] <= '0;
        else if (wr_en && addr == SEL_ADR_HI) dma_addr_q[DADDR_W-1:LO_W] <= wdata[HI_W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/scsi_hba_rdmux.sv
module scsi_hba_rdmux
  import scsi_hba_csr_pkg::*;
#(
  parameter int DADDR_W = 24,
  parameter int CNT_W   = 16,
  parameter int FCNT_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [RA_W-1:0]    addr,
  input  ctl_t               ctl,
  input  logic               dma_pend,
  input  logic               sbc_pend,
  input  logic               berr,
  input  logic               acc,
  input  logic               fifo_empty,
  input  logic               fifo_full,
  input  logic [1:0]         left_bytes,
  input  logic [DADDR_W-1:0] dma_addr,
  input  logic [CNT_W-1:0]   dma_cnt,
  input  logic [FCNT_W-1:0]  fifo_cnt,
  input  logic [VEC_W-1:0]   vec,
  input  logic [AM_W-1:0]    am,
  output logic [REG_W-1:0]   rdata_q
);
  localparam int LO_W = (DADDR_W > REG_W) ? REG_W : DADDR_W;
  logic [REG_W-1:0] sel_d;

  always_comb begin
    case (addr)
      SEL_CTL:    sel_d = {1'b0, acc, berr, 1'b0, fifo_full, fifo_empty,
                           sbc_pend, dma_pend, left_bytes, ctl};
      SEL_VEC:    sel_d = {{(REG_W-AM_W-VEC_W){1'b0}}, am, vec};
      SEL_ADR_LO: sel_d = REG_W'(dma_addr[LO_W-1:0]);
      SEL_ADR_HI: sel_d = REG_W'(dma_addr >> LO_W);
      SEL_DCNT:   sel_d = REG_W'(dma_cnt);
      SEL_FCNT:   sel_d = REG_W'(fifo_cnt);
      default:    sel_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= sel_d;
  end
endmodule

// File: rtl/scsi_hba_csr.sv
module scsi_hba_csr
  import scsi_hba_csr_pkg::*;
#(
  parameter int DADDR_W = 24,
  parameter int CNT_W   = 16,
  parameter int FCNT_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               sbc_irq_in,
  input  logic               dma_irq_in,
  input  logic               fifo_empty,
  input  logic               fifo_full,
  input  logic [1:0]         left_bytes,
  input  logic               dma_bus_err,
  input  logic               dma_active,
  output logic               irq,
  output logic               sbc_rst_n,
  output logic               fifo_rst_n,
  output logic               dir_to_dev,
  output logic               dma_en,
  output logic               pack_long,
  output logic [DADDR_W-1:0] dma_addr,
  output logic [CNT_W-1:0]   dma_count,
  output logic [FCNT_W-1:0]  fifo_count,
  output logic [VEC_W-1:0]   int_vector,
  output logic [AM_W-1:0]    addr_mod
);
  ctl_t ctl_q;
  logic dma_pend, sbc_pend, berr_flag, acc_flag, ie_q;

  scsi_hba_ctl u_ctl (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .sbc_src(sbc_irq_in), .dma_src(dma_irq_in),
    .dma_bus_err(dma_bus_err), .dma_active(dma_active), .ctl_q(ctl_q),
    .dma_pend_q(dma_pend), .sbc_pend_q(sbc_pend), .berr_q(berr_flag),
    .acc_q(acc_flag), .irq_q(irq)
  );

  scsi_hba_xfer_regs #(.DADDR_W(DADDR_W), .CNT_W(CNT_W), .FCNT_W(FCNT_W)) u_xfer (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .dma_addr_q(dma_addr), .dma_cnt_q(dma_count), .fifo_cnt_q(fifo_count),
    .vec_q(int_vector), .am_q(addr_mod)
  );

  scsi_hba_rdmux #(.DADDR_W(DADDR_W), .CNT_W(CNT_W), .FCNT_W(FCNT_W)) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(reg_rd), .addr(reg_addr), .ctl(ctl_q),
    .dma_pend(dma_pend), .sbc_pend(sbc_pend), .berr(berr_flag), .acc(acc_flag),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .left_bytes(left_bytes),
    .dma_addr(dma_addr), .dma_cnt(dma_count), .fifo_cnt(fifo_count),
    .vec(int_vector), .am(addr_mod), .rdata_q(reg_rdata)
  );

  assign ie_q       = ctl_q.ie;
  assign sbc_rst_n  = ctl_q.sbc_rst_n;
  assign fifo_rst_n = ctl_q.fifo_rst_n;
  assign dir_to_dev = ctl_q.dir_to_dev;
  assign dma_en     = ctl_q.dma_en;
  assign pack_long  = ctl_q.pack_long;
endmodule

// File: rtl/scsi_hba_csr_chk.sv
module scsi_hba_csr_chk
  import scsi_hba_csr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FCNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [RA_W-1:0]  addr,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] rdata,
  input logic             irq,
  input logic             ie,
  input logic             sbc_rst_n,
  input logic             fifo_rst_n,
  input logic             sbc_src,
  input logic             sbc_pend,
  input logic [CNT_W-1:0] dma_cnt,
  input logic [FCNT_W-1:0] fifo_cnt
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!sbc_rst_n && !fifo_rst_n && !irq));

  assert_irq_gated_R3: assert property (@(posedge clk) disable iff (rst)
    irq |-> ie);

  assert_src_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (!ie && !sbc_pend) |=> !sbc_pend);

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == SEL_IACK && !sbc_src) |=> !sbc_pend);

  assert_dcnt_mirror_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == SEL_DCNT) |=> fifo_cnt == $past(wdata[FCNT_W-1:0]));

  assert_fcnt_mirror_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == SEL_FCNT) |=> dma_cnt == CNT_W'($past(wdata[FCNT_W-1:0])));

  assert_vec_top_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == SEL_VEC) |=> rdata[15:14] == 2'b00);
endmodule

bind scsi_hba_csr scsi_hba_csr_chk #(.CNT_W(CNT_W), .FCNT_W(FCNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
  .wdata(reg_wdata), .rdata(reg_rdata), .irq(irq), .ie(ie_q),
  .sbc_rst_n(sbc_rst_n), .fifo_rst_n(fifo_rst_n), .sbc_src(sbc_irq_in),
  .sbc_pend(sbc_pend), .dma_cnt(dma_count), .fifo_cnt(fifo_count)
);

// File: tb/scsi_hba_csr_tb.sv
module scsi_hba_csr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DADDR_W = 24;
  localparam int CNT_W   = 16;
  localparam int FCNT_W  = 12;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic sbc_irq_in = 0, dma_irq_in = 0, fifo_empty = 1, fifo_full = 0;
  logic [1:0] left_bytes = 0;
  logic dma_bus_err = 0, dma_active = 0;
  logic irq, sbc_rst_n, fifo_rst_n, dir_to_dev, dma_en, pack_long;
  logic [DADDR_W-1:0] dma_addr;
  logic [CNT_W-1:0] dma_count;
  logic [FCNT_W-1:0] fifo_count;
  logic [7:0] int_vector;
  logic [5:0] addr_mod;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit cmp_en = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_hba_csr #(.DADDR_W(DADDR_W), .CNT_W(CNT_W), .FCNT_W(FCNT_W)) u_dut (.*);

  // ---------------- behavioural reference model ----------------
  bit m_srst, m_frst, m_ie, m_dir, m_dma, m_pack;
  bit m_dp, m_sp, m_berr, m_acc, m_irq;
  int m_vec, m_am, m_addr, m_cnt, m_fcnt, m_rd;

  function automatic int model_read(int a);
    case (a)
      0: return (m_acc << 14) | (m_berr << 13) | (fifo_full << 11) | (fifo_empty << 10) |
                (m_sp << 9) | (m_dp << 8) | (left_bytes << 6) | (m_pack << 5) |
                (m_dma << 4) | (m_dir << 3) | (m_ie << 2) | (m_frst << 1) | m_srst;
      1: return (m_am << 8) | m_vec;
      2: return m_addr & 'hFFFF;
      3: return m_addr >> 16;
      4: return m_cnt;
      5: return m_fcnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit old_ie, old_frst;
    int w;
    cmp_en <= 1;
    if (rst) begin
      {m_srst, m_frst, m_ie, m_dir, m_dma, m_pack} = 0;
      {m_dp, m_sp, m_berr, m_acc, m_irq} = 0;
      m_vec = 0; m_am = 0; m_addr = 0; m_cnt = 0; m_fcnt = 0; m_rd = 0;
    end else begin
      old_ie = m_ie; old_frst = m_frst; w = reg_wdata;
      if (reg_rd) m_rd = model_read(reg_addr);
      if (reg_wr && reg_addr == 4) m_dp = 0;
      if (old_ie && dma_irq_in) m_dp = 1;
      if (reg_rd && reg_addr == 6) m_sp = 0;
      if (old_ie && sbc_irq_in) m_sp = 1;
      if (!old_frst) begin m_berr = 0; m_acc = 0; end
      else begin
        if (dma_bus_err) m_berr = 1;
        if (reg_wr && dma_active) m_acc = 1;
      end
      if (reg_wr) case (reg_addr)
        0: begin m_srst = w[0]; m_frst = w[1]; m_ie = w[2]; m_dir = w[3]; m_dma = w[4]; m_pack = w[5]; end
        1: begin m_vec = w & 'hFF; m_am = (w >> 8) & 'h3F; end
        2: m_addr = (m_addr & 'hFF0000) | w;
        3: m_addr = (m_addr & 'hFFFF) | ((w & 'hFF) << 16);
        4: begin m_cnt = w; m_fcnt = w & 'hFFF; end
        5: begin m_fcnt = w & 'hFFF; m_cnt = w & 'hFFF; end
        default: ;
      endcase
      m_irq = m_ie && (m_dp || m_sp);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (cmp_en && !done) begin
    chk("R3 irq", irq, m_irq);
    chk("R2 ctl", {pack_long, dma_en, dir_to_dev, fifo_rst_n, sbc_rst_n},
        {m_pack, m_dma, m_dir, m_frst, m_srst});
    chk("R10 addr", dma_addr, m_addr);
    chk("R6 counts", {dma_count, fifo_count}, {m_cnt[15:0], m_fcnt[11:0]});
    chk("R7 vec", {addr_mod, int_vector}, {m_am[5:0], m_vec[7:0]});
    chk("R8 rdata", reg_rdata, m_rd);
  end

  // ---------------- stimulus ----------------
  task automatic step(); @(posedge clk); #2; endtask

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = 16'(d); step(); reg_wr = 0;
  endtask

  task automatic rd_exp(int a, int exp, string tag);
    reg_rd = 1; reg_addr = 3'(a); step(); reg_rd = 0;
    chk(tag, reg_rdata, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 0;
    // R1 reset state
    chk("R1 sbc_rst_n", sbc_rst_n, 0);
    chk("R1 fifo_rst_n", fifo_rst_n, 0);
    rd_exp(0, 'h0400, "R1 ctl after reset");
    // R2 writable fields only
    wr(0, 'hFFC7);
    rd_exp(0, 'h0407, "R2 read-only bits untouched");
    wr(0, 'h003F);
    chk("R2 all fields set", {pack_long, dma_en, dir_to_dev}, 3'b111);
    // R3 sources ignored while disabled
    wr(0, 'h0003);
    sbc_irq_in = 1; dma_irq_in = 1; step(); sbc_irq_in = 0; dma_irq_in = 0;
    chk("R3 irq low when disabled", irq, 0);
    rd_exp(0, 'h0403, "R3 no pending when disabled");
    // R3 enabled
    wr(0, 'h0007);
    sbc_irq_in = 1; step(); sbc_irq_in = 0;
    chk("R3 irq raised", irq, 1);
    rd_exp(0, 'h0607, "R3 protocol pending");
    wr(0, 'h0003);
    chk("R3 irq gated off", irq, 0);
    wr(0, 'h0007);
    chk("R3 irq back on", irq, 1);
    // R4 acknowledge
    rd_exp(6, 0, "R4 ack reads zero");
    chk("R4 irq cleared", irq, 0);
    sbc_irq_in = 1; step(); sbc_irq_in = 0;
    sbc_irq_in = 1; reg_rd = 1; reg_addr = 6; step(); reg_rd = 0; sbc_irq_in = 0;
    rd_exp(0, 'h0607, "R4 set wins over ack");
    rd_exp(6, 0, "R4 ack");
    rd_exp(0, 'h0407, "R4 cleared");
    // R5 / R6
    dma_irq_in = 1; step(); dma_irq_in = 0;
    rd_exp(0, 'h0507, "R5 dma pending");
    wr(4, 'h1234);
    rd_exp(0, 'h0407, "R5 cleared by count write");
    chk("R6 dma count", dma_count, 'h1234);
    chk("R6 fifo count from dma", fifo_count, 'h234);
    wr(5, 'hFABC);
    chk("R6 fifo count", fifo_count, 'hABC);
    chk("R6 dma count from fifo", dma_count, 'h0ABC);
    rd_exp(4, 'h0ABC, "R6 read dma count");
    // R7
    wr(1, 'hFFFF);
    rd_exp(1, 'h3FFF, "R7 vector/modifier");
    chk("R7 outputs", {addr_mod, int_vector}, 14'h3FFF);
    // R10
    wr(2, 'hBEEF); wr(3, 'h12A5);
    chk("R10 dma address", dma_addr, 24'hA5BEEF);
    rd_exp(3, 'h00A5, "R10 upper read");
    rd_exp(2, 'hBEEF, "R10 lower read");
    // R8 status
    left_bytes = 2'b10; fifo_full = 1; fifo_empty = 0;
    rd_exp(0, 'h0887, "R8 status fields");
    // R9 sticky flags
    dma_bus_err = 1; step(); dma_bus_err = 0;
    rd_exp(0, 'h2887, "R9 bus error flag");
    dma_active = 1; wr(1, 0); dma_active = 0;
    rd_exp(0, 'h6887, "R9 access flag");
    wr(0, 'h0005);
    rd_exp(0, 'h6885, "R9 flags before clear");
    rd_exp(0, 'h0885, "R9 flags cleared in fifo reset");
    dma_bus_err = 1; step(); dma_bus_err = 0;
    rd_exp(0, 'h0885, "R9 no set during fifo reset");
    step(); step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule